// File: doc/BRIEF.md
# Parallel-Port Result Frame Sender

This block is the peripheral end of an enhanced parallel port link that carries one frame of processing results to a host per processing period. When the internal pipeline pulses its valid signal, the block captures five 14-bit results in one step, raises the interrupt line toward the host, and then answers ten host read cycles, one byte per cycle. Each value goes out as two bytes.

Every read cycle starts when the host pulls its active-low data strobe low. The block passes the strobe through a synchronizer, puts the next byte on the data bus, and raises wait to acknowledge. When the host lets the strobe go high again, the block drops wait and moves to the next byte. Because a byte only advances on the synchronized release that follows an acknowledge, a host that lets go of the strobe before wait rises still gets exactly one byte per strobe pulse. At the nominal 800 ns host cycle, the ten bytes take about 8 us. This leaves margin inside the roughly 13 us read window of a 25 us frame.

Top module: `epp_frame_tx`

## Requirements
- R1: While reset is high and after reset, host_wait, host_irq and overrun are 0 and host_data is 0.
- R2: A res_valid pulse while no frame is pending captures res_data and sets host_irq high at the next clock edge.
- R3: The frame is sent as 10 bytes in this order: byte 2k is bits [14k+7:14k] of res_data, and byte 2k+1 is {2'b00, bits [14k+13:14k+8]}, for values k = 0 to 4.
- R4: The strobe is first sampled low at a rising edge. On the third rising edge from and including that one, host_wait goes high with the current byte on host_data. host_data stays stable while host_wait is high.
- R5: The strobe is first sampled high again at a rising edge. On the third rising edge from and including that one, host_wait goes low and the byte index advances by one.
- R6: host_irq falls on the same edge as host_wait falls at the end of the tenth byte, and the frame is then no longer pending.
- R7: A res_valid pulse while a frame is pending sets overrun. overrun stays set until reset, and the frame being read is left unchanged.
- R8: A strobe pulse while no frame is pending leaves host_wait low and host_data unchanged, and does not advance the byte index. The next frame still starts at byte 0.
- R9: If the host releases the strobe before host_wait rises, the block still delivers exactly one byte for that pulse: wait rises once and falls once, with no byte skipped or repeated.
- R10: A frame captured after a completed frame is read starting at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle pulse marking res_data as a new frame |
| res_data | input | 70 | Five 14-bit results, value k at bits [14k+13:14k] |
| host_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| host_wait | output | 1 | Acknowledge: high while the byte on host_data is valid |
| host_irq | output | 1 | High while a frame waits to be read |
| host_data | output | 8 | Byte presented to the host |
| overrun | output | 1 | Sticky flag: a frame arrived while one was still pending |

## Verification
The hardest case to reach is a strobe pulse so short that the host releases it before wait has risen. From the ports this looks like a byte that might be lost or counted twice. The bench drives pulses that are low for only two clock periods in the middle of a frame and confirms that the following bytes keep their order. It also pushes a second valid pulse into a frame that is partly read, and sends stray strobes while no frame is pending. A behavioural model built on queues follows every edge, so any skipped or repeated byte shows up as a data mismatch.

// File: rtl/epp_tx_pkg.sv
package epp_tx_pkg;
    localparam int DEF_NUM_VALS = 5;
    localparam int DEF_VAL_W    = 14;
    localparam int DEF_BYTE_W   = 8;
    localparam int DEF_SYNC_STG = 2;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_e;

    function automatic int bytes_per_val(input int val_w, input int byte_w);
        return (val_w + byte_w - 1) / byte_w;
    endfunction
endpackage

// File: rtl/epp_strobe_sync.sv
module epp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n_async,
    output logic strobe_lvl,
    output logic strobe_fell
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], strobe_n_async};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign strobe_lvl  = chain_q[STAGES-1];
    assign strobe_fell = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/epp_frame_store.sv
module epp_frame_store
    import epp_tx_pkg::*;
#(
    parameter int NUM_VALS = DEF_NUM_VALS,
    parameter int VAL_W    = DEF_VAL_W,
    parameter int BYTE_W   = DEF_BYTE_W,
    localparam int BPV     = bytes_per_val(VAL_W, BYTE_W),
    localparam int NBYTES  = NUM_VALS * BPV,
    localparam int IDX_W   = $clog2(NBYTES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [NUM_VALS*VAL_W-1:0] din,
    input  logic [IDX_W-1:0]          sel,
    output logic [BYTE_W-1:0]         byte_out
);
    localparam int PAD_W = BPV * BYTE_W;

    logic [NUM_VALS*VAL_W-1:0] frame_q;
    logic [BYTE_W-1:0]         byte_arr [NBYTES];

    always_ff @(posedge clk) begin
        if (rst)       frame_q <= '0;
        else if (load) frame_q <= din;
    end

    for (genvar v = 0; v < NUM_VALS; v++) begin : g_val
        logic [PAD_W-1:0] padded;
        assign padded = PAD_W'(frame_q[v*VAL_W +: VAL_W]);
        for (genvar b = 0; b < BPV; b++) begin : g_byte
            assign byte_arr[v*BPV + b] = padded[b*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        byte_out = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (sel == IDX_W'(i)) byte_out = byte_arr[i];
        end
    end
endmodule

// File: rtl/epp_hs_ctl.sv
module epp_hs_ctl
    import epp_tx_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = 10,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic              strobe_lvl,
    input  logic              strobe_fell,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              load,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              wait_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              overrun_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    hs_state_e   state_q;
    logic        pend_q;

    assign load = frame_valid & ~pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= HS_IDLE;
            pend_q    <= 1'b0;
            byte_idx  <= '0;
            wait_o    <= 1'b0;
            irq_o     <= 1'b0;
            data_o    <= '0;
            overrun_o <= 1'b0;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (strobe_fell && pend_q) begin
                        data_o  <= byte_in;
                        wait_o  <= 1'b1;
                        state_q <= HS_ACK;
                    end
                end
                HS_ACK: begin
                    if (strobe_lvl) begin
                        wait_o  <= 1'b0;
                        state_q <= HS_IDLE;
                        if (byte_idx == LAST_IDX) begin
                            byte_idx <= '0;
                            pend_q   <= 1'b0;
                            irq_o    <= 1'b0;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
            if (load) begin
                pend_q   <= 1'b1;
                irq_o    <= 1'b1;
                byte_idx <= '0;
            end
            if (frame_valid && pend_q) overrun_o <= 1'b1;
        end
    end
endmodule

// File: rtl/epp_frame_tx.sv
module epp_frame_tx
    import epp_tx_pkg::*;
#(
    parameter int NUM_VALS = DEF_NUM_VALS,
    parameter int VAL_W    = DEF_VAL_W,
    parameter int BYTE_W   = DEF_BYTE_W,
    parameter int SYNC_STG = DEF_SYNC_STG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      res_valid,
    input  logic [NUM_VALS*VAL_W-1:0] res_data,
    input  logic                      host_strobe_n,
    output logic                      host_wait,
    output logic                      host_irq,
    output logic [BYTE_W-1:0]         host_data,
    output logic                      overrun
);
    localparam int NBYTES = NUM_VALS * bytes_per_val(VAL_W, BYTE_W);
    localparam int IDX_W  = $clog2(NBYTES);

    logic              stb_lvl, stb_fell, load;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] cur_byte;

    epp_strobe_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk(clk), .rst(rst), .strobe_n_async(host_strobe_n),
        .strobe_lvl(stb_lvl), .strobe_fell(stb_fell)
    );

    epp_frame_store #(.NUM_VALS(NUM_VALS), .VAL_W(VAL_W), .BYTE_W(BYTE_W)) i_store (
        .clk(clk), .rst(rst), .load(load), .din(res_data),
        .sel(idx), .byte_out(cur_byte)
    );

    epp_hs_ctl #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_ctl (
        .clk(clk), .rst(rst), .frame_valid(res_valid),
        .strobe_lvl(stb_lvl), .strobe_fell(stb_fell), .byte_in(cur_byte),
        .load(load), .byte_idx(idx), .wait_o(host_wait), .irq_o(host_irq),
        .data_o(host_data), .overrun_o(overrun)
    );
endmodule

// File: rtl/epp_frame_tx_chk.sv
module epp_frame_tx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_strobe_n,
    input logic              host_wait,
    input logic              host_irq,
    input logic [BYTE_W-1:0] host_data,
    input logic              overrun
);
    // R4
    wait_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_wait) |-> host_irq);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wait && $past(host_wait)) |-> $stable(host_data));

    // R5
    wait_drop_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_wait) |-> $past(host_strobe_n, 2));

    // R6
    irq_drop_with_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_irq) |-> $fell(host_wait));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(overrun) |-> overrun);
endmodule

bind epp_frame_tx epp_frame_tx_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk(clk), .rst(rst), .host_strobe_n(host_strobe_n),
    .host_wait(host_wait), .host_irq(host_irq),
    .host_data(host_data), .overrun(overrun)
);

// File: tb/test_epp_frame_tx.sv
module test_epp_frame_tx;
    logic        clk = 0;
    logic        rst = 1;
    logic        res_valid = 0;
    logic [69:0] res_data = '0;
    logic        host_strobe_n = 1;
    logic        host_wait, host_irq, overrun;
    logic [7:0]  host_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    epp_frame_tx i_epp_frame_tx (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .host_strobe_n(host_strobe_n), .host_wait(host_wait),
        .host_irq(host_irq), .host_data(host_data), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [69:0] f, input int i);
        logic [13:0] v;
        v = f[14*(i/2) +: 14];
        return (i % 2 == 0) ? v[7:0] : {2'b00, v[13:8]};
    endfunction

    // behavioural reference model
    int          hist[$];
    logic [7:0]  q_bytes[$];
    logic        m_wait, m_irq, m_ovr, m_pend, m_ack, m_live;
    logic [7:0]  m_data;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{1, 1, 1};
            q_bytes.delete();
            m_wait = 0; m_irq = 0; m_ovr = 0; m_pend = 0; m_ack = 0; m_data = 0;
            m_live = 1;
        end else begin
            int  n;
            int  lvl, old;
            logic was_pend;
            n = hist.size();
            lvl = hist[n-2];
            old = hist[n-3];
            was_pend = m_pend;
            if (!m_ack) begin
                if (old == 1 && lvl == 0 && was_pend) begin
                    m_data = q_bytes.pop_front();
                    m_wait = 1; m_ack = 1;
                end
            end else if (lvl == 1) begin
                m_wait = 0; m_ack = 0;
                if (q_bytes.size() == 0) begin m_pend = 0; m_irq = 0; end
            end
            if (res_valid && !was_pend) begin
                for (int i = 0; i < 10; i++) q_bytes.push_back(exp_byte(res_data, i));
                m_pend = 1; m_irq = 1;
            end else if (res_valid && was_pend) begin
                m_ovr = 1;
            end
        end
        hist.push_back(int'(host_strobe_n));
        if (hist.size() > 8) void'(hist.pop_front());
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk("R4 wait model", {31'b0, host_wait}, {31'b0, m_wait});
            chk("R2 irq model", {31'b0, host_irq}, {31'b0, m_irq});
            chk("R3 data model", {24'b0, host_data}, {24'b0, m_data});
            chk("R7 overrun model", {31'b0, overrun}, {31'b0, m_ovr});
        end
    end

    task automatic push_frame(input logic [69:0] f);
        @(negedge clk);
        res_data  = f;
        res_valid = 1;
        @(negedge clk);
        res_valid = 0;
    endtask

    // one host read; short=1 releases the strobe after two low cycles
    task automatic host_read(input bit short, output logic [7:0] b);
        int t;
        @(negedge clk);
        host_strobe_n = 0;
        if (short) begin
            repeat (2) @(negedge clk);
            host_strobe_n = 1;
        end
        t = 0;
        while (host_wait !== 1 && t < 60) begin @(negedge clk); t++; end
        b = host_data;
        if (!short) begin
            repeat (20) @(negedge clk);
            host_strobe_n = 1;
        end
        t = 0;
        while (host_wait !== 0 && t < 60) begin @(negedge clk); t++; end
        repeat (19) @(negedge clk);
    endtask

    task automatic run_tests();
        logic [69:0] fa, fb, fc;
        logic [7:0]  b;
        bit          seen;
        fa = {14'h3ABC, 14'h0001, 14'h2FFF, 14'h1234, 14'h3C0F};
        fb = {14'h0AAA, 14'h1555, 14'h3FFF, 14'h0000, 14'h2468};
        fc = {14'h1111, 14'h2222, 14'h3333, 14'h0444, 14'h0555};

        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 wait", {31'b0, host_wait}, 0);
        chk("R1 irq", {31'b0, host_irq}, 0);
        chk("R1 data", {24'b0, host_data}, 0);
        chk("R1 overrun", {31'b0, overrun}, 0);
        rst = 0;
        repeat (2) @(negedge clk);

        // R8 stray strobe with nothing pending
        seen = 0;
        host_strobe_n = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (host_wait) seen = 1; end
        host_strobe_n = 1;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (host_wait) seen = 1; end
        chk("R8 no wait on stray strobe", {31'b0, seen}, 0);
        chk("R8 data unchanged", {24'b0, host_data}, 0);

        // R2 frame capture
        push_frame(fa);
        chk("R2 irq raised", {31'b0, host_irq}, 1);

        // R3 full frame, nominal cycles, with R9 short pulses on bytes 3 and 6
        for (int i = 0; i < 10; i++) begin
            host_read(i == 3 || i == 6, b);
            chk((i == 3 || i == 6) ? "R9 short pulse byte" : "R3 byte order",
                {24'b0, b}, {24'b0, exp_byte(fa, i)});
            if (i == 0) chk("R8 first byte after stray", {24'b0, b}, {24'b0, exp_byte(fa, 0)});
        end
        // R6
        chk("R6 irq dropped", {31'b0, host_irq}, 0);
        chk("R1 overrun still clear", {31'b0, overrun}, 0);

        // R10 next frame restarts at byte 0; R7 overrun mid-frame
        push_frame(fb);
        for (int i = 0; i < 10; i++) begin
            host_read(0, b);
            chk("R10 byte of second frame", {24'b0, b}, {24'b0, exp_byte(fb, i)});
            if (i == 2) begin
                push_frame(fc);
                chk("R7 overrun set", {31'b0, overrun}, 1);
            end
        end
        chk("R7 overrun sticky", {31'b0, overrun}, 1);
        chk("R6 irq low after second frame", {31'b0, host_irq}, 0);

        // R8 strobe after frame end does not advance
        seen = 0;
        host_strobe_n = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (host_wait) seen = 1; end
        host_strobe_n = 1;
        repeat (5) @(negedge clk);
        chk("R8 idle strobe ignored", {31'b0, seen}, 0);
        chk("R8 data holds last byte", {24'b0, host_data}, {24'b0, exp_byte(fb, 9)});

        // R10 third frame, all short pulses (R9)
        push_frame(fc);
        for (int i = 0; i < 10; i++) begin
            host_read(1, b);
            chk("R9 R10 short pulse frame", {24'b0, b}, {24'b0, exp_byte(fc, i)});
        end
        chk("R6 irq low after third frame", {31'b0, host_irq}, 0);

        // R1 reset clears sticky overrun
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk);
        chk("R1 overrun cleared", {31'b0, overrun}, 0);
        rst = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        m_live = 0;
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule